// File: doc/BRIEF.md
# Two-Write-Port Register File

This block is the architectural register store of a datapath that can retire two results per clock. It holds 32 words of 32 bits each. Two write ports can each update one register on the same rising edge, and two read ports return register contents combinationally. Entry zero is a constant: it reads as zero and no write can change it.

Each write port has an enable, a 5-bit register select and a 32-bit data word. A write decoder turns each enabled select into a one-hot hit vector. A register loads when either port hits it. When both ports hit the same register, write port A supplies the data. Reads return the value held before the coming edge, because there is no bypass from a write to a read in the same cycle. The asynchronous reset clears every entry, so a test can start from a known state.

Top module: `dual_wport_regfile`

## Requirements
- R1: While `rst_n` is low, every entry is cleared to zero, and after reset every address reads 32'h0 on both read ports.
- R2: Address 0 always reads 32'h0 on both read ports. A write from either port to address 0 changes nothing.
- R3: An enabled write from one port to a nonzero address is visible on the read ports from the rising edge that samples it onward. Before that edge, a read of the same address returns the old value.
- R4: When both write ports are enabled with equal nonzero selects, the addressed register takes the port A data and the port B data is discarded.
- R5: When both ports are enabled with different nonzero selects, both registers update on the same edge, each with its own port's data.
- R6: A port whose enable is 0 changes no register, whatever its select and data inputs hold.
- R7: The two read ports are independent. Each returns the entry named by its own select, including when both name the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset that clears all entries |
| wr_a_en | input | 1 | Write port A enable (1 = write) |
| wr_a_sel | input | 5 | Write port A register select |
| wr_a_data | input | 32 | Write port A data |
| wr_b_en | input | 1 | Write port B enable (1 = write) |
| wr_b_sel | input | 5 | Write port B register select |
| wr_b_data | input | 32 | Write port B data |
| rd_a_sel | input | 5 | Read port A register select |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_sel | input | 5 | Read port B register select |
| rd_b_data | output | 32 | Read port B data (combinational) |

## Verification
A read follows its select with no clock delay, so the bench samples the read ports in the same low clock phase in which it drives the selects. A write appears one edge later. The bench drives the write inputs on a falling edge and updates its reference array at the next rising edge. It then reads back on the following falling edge, which places every write check exactly one edge after its stimulus. The no-bypass check reads before the rising edge that would commit the write. The clocked properties also look one edge ahead, using `|=>` and `$past` of the write inputs.

// File: rtl/rf_pkg.sv
package rf_pkg;
    parameter int unsigned RF_DEPTH_DEF = 32;
    parameter int unsigned RF_WIDTH_DEF = 32;
    localparam int unsigned RF_SEL_W_DEF = $clog2(RF_DEPTH_DEF);
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
    parameter int unsigned DEPTH = rf_pkg::RF_DEPTH_DEF,
    localparam int unsigned SEL_W = $clog2(DEPTH)
) (
    input  logic             a_en,
    input  logic [SEL_W-1:0] a_sel,
    input  logic             b_en,
    input  logic [SEL_W-1:0] b_sel,
    output logic [DEPTH-1:0] load,
    output logic [DEPTH-1:0] take_a
);
    // entry zero never loads
    assign load[0]   = 1'b0;
    assign take_a[0] = 1'b0;

    for (genvar i = 1; i < DEPTH; i++) begin : g_hit
        logic hit_a;
        logic hit_b;
        assign hit_a     = a_en && (a_sel == SEL_W'(i));
        assign hit_b     = b_en && (b_sel == SEL_W'(i));
        assign load[i]   = hit_a | hit_b;
        assign take_a[i] = hit_a;   // port A has priority on a shared target
    end
endmodule

// File: rtl/rf_store.sv
module rf_store #(
    parameter int unsigned DEPTH = rf_pkg::RF_DEPTH_DEF,
    parameter int unsigned WIDTH = rf_pkg::RF_WIDTH_DEF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DEPTH-1:0]            load,
    input  logic [DEPTH-1:0]            take_a,
    input  logic [WIDTH-1:0]            a_data,
    input  logic [WIDTH-1:0]            b_data,
    output logic [DEPTH-1:0][WIDTH-1:0] contents
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] regs;
    } state_t;

    state_t st_d;
    state_t st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 1; i < int'(DEPTH); i++) begin
            if (load[i]) begin
                st_d.regs[i] = take_a[i] ? a_data : b_data;
            end
        end
        st_d.regs[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign contents = st_q.regs;
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port #(
    parameter int unsigned DEPTH = rf_pkg::RF_DEPTH_DEF,
    parameter int unsigned WIDTH = rf_pkg::RF_WIDTH_DEF,
    localparam int unsigned SEL_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][WIDTH-1:0] contents,
    input  logic [SEL_W-1:0]            sel,
    output logic [WIDTH-1:0]            data
);
    always_comb begin
        if (sel == '0) begin
            data = '0;
        end else begin
            data = contents[sel];
        end
    end
endmodule

// File: rtl/dual_wport_regfile.sv
module dual_wport_regfile #(
    parameter int unsigned DEPTH = rf_pkg::RF_DEPTH_DEF,
    parameter int unsigned WIDTH = rf_pkg::RF_WIDTH_DEF,
    localparam int unsigned SEL_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_a_en,
    input  logic [SEL_W-1:0] wr_a_sel,
    input  logic [WIDTH-1:0] wr_a_data,
    input  logic             wr_b_en,
    input  logic [SEL_W-1:0] wr_b_sel,
    input  logic [WIDTH-1:0] wr_b_data,
    input  logic [SEL_W-1:0] rd_a_sel,
    output logic [WIDTH-1:0] rd_a_data,
    input  logic [SEL_W-1:0] rd_b_sel,
    output logic [WIDTH-1:0] rd_b_data
);
    localparam int unsigned N_RD = 2;

    logic [DEPTH-1:0]            load;
    logic [DEPTH-1:0]            take_a;
    logic [DEPTH-1:0][WIDTH-1:0] contents;
    logic [N_RD-1:0][SEL_W-1:0]  rd_sel_v;
    logic [N_RD-1:0][WIDTH-1:0]  rd_data_v;

    rf_wr_decode #(.DEPTH(DEPTH)) u_dec (
        .a_en   (wr_a_en),
        .a_sel  (wr_a_sel),
        .b_en   (wr_b_en),
        .b_sel  (wr_b_sel),
        .load   (load),
        .take_a (take_a)
    );

    rf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .take_a   (take_a),
        .a_data   (wr_a_data),
        .b_data   (wr_b_data),
        .contents (contents)
    );

    assign rd_sel_v[0] = rd_a_sel;
    assign rd_sel_v[1] = rd_b_sel;

    for (genvar g = 0; g < N_RD; g++) begin : g_rd
        rf_rd_port #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rd (
            .contents (contents),
            .sel      (rd_sel_v[g]),
            .data     (rd_data_v[g])
        );
    end

    assign rd_a_data = rd_data_v[0];
    assign rd_b_data = rd_data_v[1];
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int unsigned DEPTH = rf_pkg::RF_DEPTH_DEF,
    parameter int unsigned WIDTH = rf_pkg::RF_WIDTH_DEF,
    localparam int unsigned SEL_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_a_en,
    input logic [SEL_W-1:0] wr_a_sel,
    input logic [WIDTH-1:0] wr_a_data,
    input logic             wr_b_en,
    input logic [SEL_W-1:0] wr_b_sel,
    input logic [WIDTH-1:0] wr_b_data,
    input logic [SEL_W-1:0] rd_a_sel,
    input logic [WIDTH-1:0] rd_a_data,
    input logic [SEL_W-1:0] rd_b_sel,
    input logic [WIDTH-1:0] rd_b_data
);
    p_zero_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_sel == '0) |-> (rd_a_data == '0));

    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a_en && wr_a_sel != '0)
        |=> (rd_a_sel != $past(wr_a_sel)) || (rd_a_data == $past(wr_a_data)));

    p_collision_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a_en && wr_b_en && wr_a_sel == wr_b_sel && wr_a_sel != '0)
        |=> (rd_b_sel != $past(wr_b_sel)) || (rd_b_data == $past(wr_a_data)));

    p_dual_distinct_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b_en && wr_b_sel != '0 && !(wr_a_en && wr_a_sel == wr_b_sel))
        |=> (rd_b_sel != $past(wr_b_sel)) || (rd_b_data == $past(wr_b_data)));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_a_en && !wr_b_en)
        |=> (rd_a_sel != $past(rd_a_sel)) || $stable(rd_a_data));
endmodule

bind dual_wport_regfile rf_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_a_en   (wr_a_en),
    .wr_a_sel  (wr_a_sel),
    .wr_a_data (wr_a_data),
    .wr_b_en   (wr_b_en),
    .wr_b_sel  (wr_b_sel),
    .wr_b_data (wr_b_data),
    .rd_a_sel  (rd_a_sel),
    .rd_a_data (rd_a_data),
    .rd_b_sel  (rd_b_sel),
    .rd_b_data (rd_b_data)
);

// File: tb/dual_wport_regfile_bench.sv
`timescale 1ns/1ps
module dual_wport_regfile_bench;
    localparam int D  = 32;
    localparam int W  = 32;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_a_en, wr_b_en;
    logic [SW-1:0] wr_a_sel, wr_b_sel, rd_a_sel, rd_b_sel;
    logic [W-1:0]  wr_a_data, wr_b_data, rd_a_data, rd_b_data;

    logic [W-1:0]  model [D];
    int            n_run  = 0;
    int            n_fail = 0;
    bit            done   = 1'b0;

    always #2.5 clk = ~clk;

    dual_wport_regfile u_dual_wport_regfile (
        .clk(clk), .rst_n(rst_n),
        .wr_a_en(wr_a_en), .wr_a_sel(wr_a_sel), .wr_a_data(wr_a_data),
        .wr_b_en(wr_b_en), .wr_b_sel(wr_b_sel), .wr_b_data(wr_b_data),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data)
    );

    function automatic logic [W-1:0] want(logic [SW-1:0] s);
        return (s == '0) ? '0 : model[s];
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // combinational read of both ports, sampled 0.5 ns after the select changes
    task automatic peek(logic [SW-1:0] a, logic [SW-1:0] b, string req);
        rd_a_sel = a;
        rd_b_sel = b;
        #0.5;
        check(req, rd_a_data, want(a));
        check(req, rd_b_data, want(b));
    endtask

    // drive at a falling edge, commit at the rising edge, return at the next falling edge
    task automatic step(logic ea, logic [SW-1:0] sa, logic [W-1:0] da,
                        logic eb, logic [SW-1:0] sb, logic [W-1:0] db);
        wr_a_en = ea; wr_a_sel = sa; wr_a_data = da;
        wr_b_en = eb; wr_b_sel = sb; wr_b_data = db;
        @(posedge clk);
        if (eb && sb != '0) model[sb] = db;
        if (ea && sa != '0) model[sa] = da;   // port A wins on a shared target
        @(negedge clk);
        wr_a_en = 1'b0;
        wr_b_en = 1'b0;
    endtask

    task automatic sweep(string req);
        for (int i = 0; i < D; i += 2) peek(SW'(i), SW'(i + 1), req);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < D; i++) model[i] = '0;
        rst_n = 1'b0;
        wr_a_en = 1'b0; wr_a_sel = '0; wr_a_data = '1;
        wr_b_en = 1'b0; wr_b_sel = '0; wr_b_data = '1;
        rd_a_sel = '0;  rd_b_sel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: all entries clear after reset
        sweep("R1");

        // R3: no bypass before the edge, visible after it
        wr_a_en = 1'b1; wr_a_sel = 5'd5; wr_a_data = 32'hA5A5_0005;
        peek(5'd5, 5'd5, "R3");
        step(1'b1, 5'd5, 32'hA5A5_0005, 1'b0, 5'd0, '0);
        peek(5'd5, 5'd0, "R3");

        // R2: writes to entry zero from both ports are ignored
        step(1'b1, 5'd0, 32'hDEAD_BEEF, 1'b1, 5'd0, 32'hFEED_F00D);
        peek(5'd0, 5'd0, "R2");
        sweep("R2");

        // R4: shared target, port A data wins
        step(1'b1, 5'd9, 32'h1111_AAAA, 1'b1, 5'd9, 32'h2222_BBBB);
        peek(5'd9, 5'd9, "R4");
        check("R4", rd_a_data, 32'h1111_AAAA);

        // R5: distinct targets both update
        step(1'b1, 5'd3, 32'h0303_0303, 1'b1, 5'd4, 32'h0404_0404);
        peek(5'd3, 5'd4, "R5");
        check("R5", rd_b_data, 32'h0404_0404);

        // R6: disabled ports have no effect
        step(1'b0, 5'd3, 32'hBAD0_0001, 1'b0, 5'd4, 32'hBAD0_0002);
        peek(5'd3, 5'd4, "R6");
        step(1'b0, 5'd31, 32'hBAD0_0003, 1'b1, 5'd31, 32'h3131_3131);
        peek(5'd31, 5'd31, "R6");
        check("R6", rd_a_data, 32'h3131_3131);

        // R7: independent read ports
        peek(5'd7, 5'd7, "R7");
        peek(5'd9, 5'd3, "R7");
        peek(5'd4, 5'd0, "R7");

        // random traffic with forced collisions
        for (int n = 0; n < 600; n++) begin
            logic [SW-1:0] sa, sb;
            logic          ea, eb;
            sa = SW'($urandom_range(0, D - 1));
            sb = ($urandom_range(0, 3) == 0) ? sa : SW'($urandom_range(0, D - 1));
            ea = 1'($urandom_range(0, 1));
            eb = 1'($urandom_range(0, 1));
            step(ea, sa, $urandom, eb, sb, $urandom);
            if (ea && eb && sa == sb) peek(sa, sb, "R4");
            else if (!ea && !eb)      peek(sa, sb, "R6");
            else                      peek(sa, sb, "R5");
        end
        sweep("R7");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule